// File: doc/BRIEF.md
# I2C Controller Configuration Register

This block is the main configuration register of an I2C controller. It sits on a simple APB-style register port: a single 32-bit location with no address decode, since the surrounding register file selects it. It holds these settings for the controller core:

- master enable and slave disable;
- the bus speed class;
- 7-bit or 10-bit addressing, chosen separately for the master side and the slave side;
- whether repeated starts are allowed;
- two stop-detect qualifiers;
- the TX-empty control;
- an optional hold-bus-on-RX-full control.

Every field is driven out as its own decoded pin. Software may change the register only while the controller is switched off. An input, `ctl_enable`, carries the global enable state from the separate enable register. While it is high, writes are dropped silently.

Writing a speed code the controller cannot run is never stored. The hardware stores the highest speed the build supports instead. Bits that belong to options left out at build time read back a fixed value and ignore writes.

Top module: `i2c_cfg_reg`

## Requirements
- R1: After reset, the register reads as follows. Bit 0 (master enable) is 1. Bits 2:1 (speed) equal MAX_SPEED. Bits 3 (slave 10-bit), 4 (master 10-bit), 5 (restart enable) and 6 (slave disable) are 1. Bits 7 (stop-detect-if-addressed), 8 (TX-empty control), 9 (hold bus on RX full) and 10 (stop-detect only when master active) are 0.
- R2: A write is an access cycle with `psel`, `penable` and `pwrite` all high while `ctl_enable` is 0. It updates the register at that clock edge, and `prdata` shows the new value from the next cycle.
- R3: A write access while `ctl_enable` is 1 leaves every bit of the register unchanged.
- R4: Speed codes are 1 for standard, 2 for fast or fast-plus, and 3 for high speed. A written code from 1 to MAX_SPEED is stored as written. Code 0, or any code above MAX_SPEED, is stored as MAX_SPEED.
- R5: When DYN_TAR_UPDATE is 1, bit 4 is read-only and keeps its reset value of 1. When DYN_TAR_UPDATE is 0, bit 4 is writable.
- R6: Bit 9 is writable only when RX_HOLD_OPT is 1, and bit 10 only when STOP_MST_OPT is 1. Otherwise each bit reads 0 whatever is written.
- R7: Bits 31:11 always read 0.
- R8: `prdata` always shows the current register value, whether or not `ctl_enable` is set. `pready` is always 1, so every access takes one cycle.
- R9: Each `cfg_*` output equals its register bit at all times.
- R10: A setup-phase cycle (`penable` low) or a read access (`pwrite` low) does not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Current register value |
| pready | output | 1 | Always 1 (no wait states) |
| ctl_enable | input | 1 | Global controller enable; blocks writes when high |
| cfg_master_en | output | 1 | Master enabled |
| cfg_speed | output | 2 | Speed class |
| cfg_slv_10bit | output | 1 | Slave answers 10-bit addresses |
| cfg_mst_10bit | output | 1 | Master starts in 10-bit mode |
| cfg_restart_en | output | 1 | Repeated start permitted |
| cfg_slave_dis | output | 1 | Slave disabled |
| cfg_stop_if_addr | output | 1 | Slave reports stop only when addressed |
| cfg_tx_empty_ctl | output | 1 | TX-empty control |
| cfg_rx_hold | output | 1 | Hold bus while RX is full |
| cfg_stop_if_mst | output | 1 | Master reports stop only when active |

## Verification
Every 2-bit speed code is driven into two builds, one with maximum speed 2 and one with maximum speed 3. This catches a legalizer that lets code 0 through, that clamps the wrong way, or that treats codes above the maximum as standard speed.

Writes are fired while the controller is enabled, during setup-only cycles and as reads. A design that gates on the wrong phase or ignores the enable input would change bits there.

The build-time options are tested in both settings through a second instance. This exposes a read-only bit that still accepts writes, or a writable one that stays stuck. Random data with random enable states is checked against a bench model of the register after every access.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned USED_W = 11;

  // Field order matches bit order: bit 10 first, bit 0 last.
  typedef struct packed {
    logic       stop_mst;
    logic       rx_hold;
    logic       tx_empty;
    logic       stop_addr;
    logic       slv_dis;
    logic       restart;
    logic       mst10;
    logic       slv10;
    logic [1:0] speed;
    logic       master;
  } cfg_t;
endpackage

// File: rtl/i2c_cfg_speed_legal.sv
module i2c_cfg_speed_legal #(
  parameter int unsigned MAX_SPEED = 2
) (
  input  logic [1:0] code_in,
  output logic [1:0] code_out
);
  localparam logic [1:0] MAX_CODE = 2'(MAX_SPEED);

  always_comb begin
    if (code_in == 2'd0 || code_in > MAX_CODE) code_out = MAX_CODE;
    else code_out = code_in;
  end
endmodule

// File: rtl/i2c_cfg_store.sv
module i2c_cfg_store
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned MAX_SPEED      = 2,
  parameter bit          DYN_TAR_UPDATE = 1'b1,
  parameter bit          RX_HOLD_OPT    = 1'b0,
  parameter bit          STOP_MST_OPT   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  cfg_t       wr_val,
  output cfg_t       cur
);
  localparam cfg_t RST_VAL = '{
    stop_mst: 1'b0, rx_hold: 1'b0, tx_empty: 1'b0, stop_addr: 1'b0,
    slv_dis: 1'b1, restart: 1'b1, mst10: 1'b1, slv10: 1'b1,
    speed: 2'(MAX_SPEED), master: 1'b1
  };

  cfg_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.master    <= RST_VAL.master;
      q.speed     <= RST_VAL.speed;
      q.slv10     <= RST_VAL.slv10;
      q.restart   <= RST_VAL.restart;
      q.slv_dis   <= RST_VAL.slv_dis;
      q.stop_addr <= RST_VAL.stop_addr;
      q.tx_empty  <= RST_VAL.tx_empty;
    end else if (wr_en) begin
      q.master    <= wr_val.master;
      q.speed     <= wr_val.speed;
      q.slv10     <= wr_val.slv10;
      q.restart   <= wr_val.restart;
      q.slv_dis   <= wr_val.slv_dis;
      q.stop_addr <= wr_val.stop_addr;
      q.tx_empty  <= wr_val.tx_empty;
    end
  end

  generate
    if (DYN_TAR_UPDATE) begin : g_mst10_fixed
      always_comb q.mst10 = RST_VAL.mst10;
    end else begin : g_mst10_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.mst10 <= RST_VAL.mst10;
        else if (wr_en) q.mst10 <= wr_val.mst10;
      end
    end

    if (RX_HOLD_OPT) begin : g_hold_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.rx_hold <= 1'b0;
        else if (wr_en) q.rx_hold <= wr_val.rx_hold;
      end
    end else begin : g_hold_fixed
      always_comb q.rx_hold = 1'b0;
    end

    if (STOP_MST_OPT) begin : g_stopm_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.stop_mst <= 1'b0;
        else if (wr_en) q.stop_mst <= wr_val.stop_mst;
      end
    end else begin : g_stopm_fixed
      always_comb q.stop_mst = 1'b0;
    end
  endgenerate

  assign cur = q;
endmodule

// File: rtl/i2c_cfg_reg.sv
module i2c_cfg_reg
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned MAX_SPEED      = 2,
  parameter bit          DYN_TAR_UPDATE = 1'b1,
  parameter bit          RX_HOLD_OPT    = 1'b0,
  parameter bit          STOP_MST_OPT   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  input  logic        ctl_enable,
  output logic        cfg_master_en,
  output logic [1:0]  cfg_speed,
  output logic        cfg_slv_10bit,
  output logic        cfg_mst_10bit,
  output logic        cfg_restart_en,
  output logic        cfg_slave_dis,
  output logic        cfg_stop_if_addr,
  output logic        cfg_tx_empty_ctl,
  output logic        cfg_rx_hold,
  output logic        cfg_stop_if_mst
);
  localparam int unsigned PAD_W = REG_W - USED_W;

  logic       wr_en;
  logic [1:0] speed_ok;
  cfg_t       wr_val;
  cfg_t       cur;

  assign wr_en = psel & penable & pwrite & ~ctl_enable;

  i2c_cfg_speed_legal #(.MAX_SPEED(MAX_SPEED)) u_legal (
    .code_in (pwdata[2:1]),
    .code_out(speed_ok)
  );

  always_comb begin
    wr_val       = cfg_t'(pwdata[USED_W-1:0]);
    wr_val.speed = speed_ok;
  end

  i2c_cfg_store #(
    .MAX_SPEED(MAX_SPEED), .DYN_TAR_UPDATE(DYN_TAR_UPDATE),
    .RX_HOLD_OPT(RX_HOLD_OPT), .STOP_MST_OPT(STOP_MST_OPT)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_val), .cur(cur)
  );

  assign prdata           = {{PAD_W{1'b0}}, cur};
  assign pready           = 1'b1;
  assign cfg_master_en    = cur.master;
  assign cfg_speed        = cur.speed;
  assign cfg_slv_10bit    = cur.slv10;
  assign cfg_mst_10bit    = cur.mst10;
  assign cfg_restart_en   = cur.restart;
  assign cfg_slave_dis    = cur.slv_dis;
  assign cfg_stop_if_addr = cur.stop_addr;
  assign cfg_tx_empty_ctl = cur.tx_empty;
  assign cfg_rx_hold      = cur.rx_hold;
  assign cfg_stop_if_mst  = cur.stop_mst;
endmodule

// File: rtl/i2c_cfg_reg_chk.sv
module i2c_cfg_reg_chk #(
  parameter int unsigned MAX_SPEED = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        ctl_enable
);
  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prdata[31:11] == '0);

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && ctl_enable) |=> $stable(prdata));

  // R10
  no_access_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |=> $stable(prdata));

  // R4
  speed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prdata[2:1] != 2'd0) && (prdata[2:1] <= 2'(MAX_SPEED)));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && !ctl_enable) |=>
      (prdata[8:5] == $past(pwdata[8:5]) && prdata[3] == $past(pwdata[3])
       && prdata[0] == $past(pwdata[0])));
endmodule

bind i2c_cfg_reg i2c_cfg_reg_chk #(.MAX_SPEED(MAX_SPEED)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .pwdata(pwdata), .prdata(prdata), .ctl_enable(ctl_enable)
);

// File: tb/i2c_cfg_reg_tb.sv
module i2c_cfg_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] pwdata = '0;
  logic        ctl_enable = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic        rdy_a, rdy_b;
  logic        m_en, s10, m10, rst_en, s_dis, st_a, txe, hold, st_m;
  logic [1:0]  spd;
  logic        b_m_en, b_s10, b_m10, b_rst_en, b_s_dis, b_st_a, b_txe, b_hold, b_st_m;
  logic [1:0]  b_spd;
  int checks = 0, errors = 0;
  int cycles = 0;
  logic [31:0] exp_a, exp_b;

  always #2.5 clk = ~clk;

  // Default build: max speed 2, master 10-bit fixed, no optional bits.
  i2c_cfg_reg u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(rd_a), .pready(rdy_a), .ctl_enable(ctl_enable),
    .cfg_master_en(m_en), .cfg_speed(spd), .cfg_slv_10bit(s10),
    .cfg_mst_10bit(m10), .cfg_restart_en(rst_en), .cfg_slave_dis(s_dis),
    .cfg_stop_if_addr(st_a), .cfg_tx_empty_ctl(txe), .cfg_rx_hold(hold),
    .cfg_stop_if_mst(st_m));

  // Alternate build: max speed 3, all optional bits writable.
  i2c_cfg_reg #(.MAX_SPEED(3), .DYN_TAR_UPDATE(1'b0), .RX_HOLD_OPT(1'b1),
                .STOP_MST_OPT(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(rd_b), .pready(rdy_b), .ctl_enable(ctl_enable),
    .cfg_master_en(b_m_en), .cfg_speed(b_spd), .cfg_slv_10bit(b_s10),
    .cfg_mst_10bit(b_m10), .cfg_restart_en(b_rst_en), .cfg_slave_dis(b_s_dis),
    .cfg_stop_if_addr(b_st_a), .cfg_tx_empty_ctl(b_txe), .cfg_rx_hold(b_hold),
    .cfg_stop_if_mst(b_st_m));

  function automatic logic [31:0] rst_val(input int maxs);
    return 32'h79 | (32'(maxs) << 1);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] old, input logic [31:0] wd,
                                        input int maxs, input bit dyn, input bit hold_o,
                                        input bit stop_o);
    logic [31:0] n = '0;
    logic [1:0]  sp = wd[2:1];
    n[0]   = wd[0];
    n[2:1] = (sp == 2'd0 || int'(sp) > maxs) ? 2'(maxs) : sp;
    n[3]   = wd[3];
    n[4]   = dyn ? old[4] : wd[4];
    n[8:5] = wd[8:5];
    n[9]   = hold_o ? wd[9] : 1'b0;
    n[10]  = stop_o ? wd[10] : 1'b0;
    return n;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_both(input string tag);
    check(rd_a === exp_a, {tag, " u_dut"}, rd_a, exp_a);
    check(rd_b === exp_b, {tag, " u_alt"}, rd_b, exp_b);
  endtask

  // R9: decoded pins mirror register bits.
  task automatic check_pins();
    logic [31:0] pa, pb;
    pa = {21'b0, st_m, hold, txe, st_a, s_dis, rst_en, m10, s10, spd, m_en};
    pb = {21'b0, b_st_m, b_hold, b_txe, b_st_a, b_s_dis, b_rst_en, b_m10, b_s10, b_spd, b_m_en};
    check(pa === rd_a, "R9 pins u_dut", pa, rd_a);
    check(pb === rd_b, "R9 pins u_alt", pb, rd_b);
  endtask

  // Two-phase access; the register updates at the access-phase edge.
  task automatic access(input logic [31:0] d, input bit wr, input bit en, input bit do_enable);
    @(negedge clk);
    psel = 1'b1; pwrite = wr; pwdata = d; ctl_enable = en; penable = 1'b0;
    @(negedge clk);
    penable = do_enable;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; ctl_enable = 1'b0;
    if (wr && do_enable && !en) begin
      exp_a = model(exp_a, d, 2, 1'b1, 1'b0, 1'b0);
      exp_b = model(exp_b, d, 3, 1'b0, 1'b1, 1'b1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0f));
    exp_a = rst_val(2);
    exp_b = rst_val(3);
    repeat (3) @(negedge clk);
    // R1: reset values
    check_both("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_both("R1 after release");
    // R8: pready always 1
    check(rdy_a && rdy_b, "R8 pready", {31'b0, rdy_a & rdy_b}, 32'd1);
    check_pins();

    // R4: every speed code, both builds
    for (int c = 0; c < 4; c++) begin
      access(32'h1 | (32'(c) << 1), 1'b1, 1'b0, 1'b1);
      check_both($sformatf("R4 speed code %0d", c));
    end

    // R2/R5/R6/R7: all ones
    access(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1);
    check_both("R2 R5 R6 R7 all ones");
    check_pins();
    // R5/R6: all zeros (bit 4 stays 1 in u_dut)
    access(32'h0000_0000, 1'b1, 1'b0, 1'b1);
    check_both("R5 R6 all zeros");
    check(rd_a[4] === 1'b1, "R5 fixed bit", {31'b0, rd_a[4]}, 32'd1);

    // R3: write while enabled is dropped; R8: read value visible while enabled
    access(32'h0000_07FF, 1'b1, 1'b1, 1'b1);
    check_both("R3 locked write");
    @(negedge clk);
    ctl_enable = 1'b1;
    @(negedge clk);
    check_both("R8 read while enabled");
    ctl_enable = 1'b0;

    // R10: setup only, and read access
    access(32'h0000_05A5, 1'b1, 1'b0, 1'b0);
    check_both("R10 setup only");
    access(32'h0000_05A5, 1'b0, 1'b0, 1'b1);
    check_both("R10 read access");

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      int r;
      d = $urandom;
      r = $urandom_range(0, 9);
      access(d, r != 0, r == 1 || r == 2, r != 3);
      check_both("R2 R3 R4 R6 random");
      check_pins();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule